// File: doc/BRIEF.md
# Dual Down-Counter Timer

A register-mapped timer with two independent 32-bit down-counters. Both counters share one register window. Each counter has its own set of eight word slots, and the second set starts 0x20 bytes above the first. A counter moves down by one on every cycle in which the shared `tick` count-enable input is high and its run bit is set. When it reaches zero it sets a raw pending flag. The flag, gated by the counter's interrupt-enable bit, drives that counter's own interrupt line.

Software selects one of three behaviours with the control byte:

- **One-shot:** the counter stops at zero.
- **Periodic:** the counter restarts from its reload value.
- **Free-running:** the counter wraps to all ones.

A separate background reload register changes the next periodic reload value without disturbing the count in progress. Writing zero to the load register raises the pending flag at once.

The bus port is single-cycle. A write takes effect on the next clock edge. Read data appears on the cycle after the read strobe, and at all other times it is zero.

Word slots within each set:

| Slot (byte offset) | Register |
|---|---|
| 0x00 | load |
| 0x04 | value (read-only) |
| 0x08 | control |
| 0x0C | clear (write-only) |
| 0x10 | raw status |
| 0x14 | masked status |
| 0x18 | background reload |
| 0x1C | reserved |

Control byte bits:

| Bit | Meaning |
|---|---|
| 0 | one-shot |
| 1 | 32-bit size (stored only) |
| 5 | interrupt enable |
| 6 | periodic |
| 7 | run |

Top module: `dual_tick_timer`

## Requirements
- R1: After a synchronous reset, every readable register of both counters reads zero, both counters are stopped and both interrupt lines are low.
- R2: A write to the load slot (0x00) sets the live count and the load register to the written value. Writes to the value slot (0x04) are ignored.
- R3: With run (control bit 7) set, the count drops by one on each cycle that has `tick` high. Without `tick`, or with bit 7 clear, the count holds its value.
- R4: Writing zero to the load slot sets the raw pending flag on the next clock edge, whatever the run bit is.
- R5: In one-shot mode (bit 0 set, bit 6 clear), the step from 1 to 0 sets the raw flag, and the count then stays at 0 under further ticks.
- R6: In periodic mode (bit 6 set, which has priority over bit 0), a tick at a count of 1 or 0 sets the raw flag and reloads the count from the load register.
- R7: A write to the background slot (0x18) sets both the background register and the load register. The live count does not change, and the next periodic reload uses the new value.
- R8: In free-running mode (bits 0 and 6 clear), the step from 1 to 0 sets the raw flag, and a tick at 0 wraps the count to 0xFFFFFFFF.
- R9: A write to the clear slot (0x0C) with data bit 0 set clears the raw flag; with bit 0 clear it has no effect. An event in the same cycle as a clear leaves the flag set.
- R10: Each interrupt line equals that counter's raw flag ANDed with control bit 5. The masked status slot (0x14) returns this value in bit 0, and the raw slot (0x10) returns the raw flag in bit 0.
- R11: The counter at base 0x20 works independently of the counter at base 0x00.
- R12: Read data is valid on the cycle after the read strobe and is zero otherwise. The following read as zero and ignore writes: addresses at or above 0x40, unaligned addresses, the clear slot and slot 0x1C.
- R13: A load write in the same cycle as a counting tick wins: the count takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable shared by both counters |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 2 | Interrupt line per counter |

## Verification
The bench goes after the cycles where two causes meet:

- **Load write and tick together.** A design that let the tick win would read one below the written value.
- **Clear and reload event together.** A design that gave the clear priority would drop an interrupt.
- **Background write in mid-count.** Restarting the count on that write would shorten the current period.

The terminal behaviours of each mode are also probed. A one-shot counter that kept stepping would wrap to all ones. A free-running counter that stuck at zero would never wrap. A periodic counter loaded with 0 or 1 must flag on every tick. Finally, the bench checks that the masked status and the interrupt line both follow the enable bit, and that the second counter leaves the first untouched.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  // control byte bit positions
  localparam int CB_ONESHOT  = 0;
  localparam int CB_WIDE     = 1;
  localparam int CB_IE       = 5;
  localparam int CB_PERIODIC = 6;
  localparam int CB_RUN      = 7;
  localparam int CTL_W       = 8;

  // byte span of one counter's register set
  localparam int SET_SPAN_LOG2 = 5;

  typedef enum logic [2:0] {
    RI_LOAD  = 3'd0,
    RI_VALUE = 3'd1,
    RI_CTRL  = 3'd2,
    RI_CLEAR = 3'd3,
    RI_RAW   = 3'd4,
    RI_MASK  = 3'd5,
    RI_BG    = 3'd6,
    RI_RSVD  = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/dtmr_dec.sv
module dtmr_dec
  import dtmr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [CH_W-1:0]   ch_idx,
  output reg_idx_e          reg_idx
);
  localparam int UP_W = ADDR_W - SET_SPAN_LOG2;

  logic [UP_W-1:0] upper;

  always_comb begin
    upper   = addr[ADDR_W-1:SET_SPAN_LOG2];
    hit     = (upper < UP_W'(NUM_CH)) && (addr[1:0] == 2'b00);
    ch_idx  = upper[CH_W-1:0];
    reg_idx = reg_idx_e'(addr[SET_SPAN_LOG2-1:2]);
  end
endmodule

// File: rtl/dtmr_chan.sv
module dtmr_chan
  import dtmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr_ld,
  input  logic             wr_bg,
  input  logic             wr_ctl,
  input  logic             wr_clr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] ld_q,
  output logic [CNT_W-1:0] bg_q,
  output logic [CTL_W-1:0] ctl_q,
  output logic             ris_q,
  output logic             irq_q
);
  logic [CNT_W-1:0] cnt_n, ld_n, bg_n;
  logic [CTL_W-1:0] ctl_n;
  logic             ev, ris_n;

  always_comb begin
    cnt_n = cnt_q;
    ld_n  = ld_q;
    bg_n  = bg_q;
    ctl_n = ctl_q;
    ev    = 1'b0;
    if (ctl_q[CB_RUN] && tick) begin
      if (ctl_q[CB_PERIODIC]) begin
        if (cnt_q <= CNT_W'(1)) begin
          cnt_n = ld_q;
          ev    = 1'b1;
        end else begin
          cnt_n = cnt_q - CNT_W'(1);
        end
      end else if (ctl_q[CB_ONESHOT]) begin
        if (cnt_q != '0) begin
          cnt_n = cnt_q - CNT_W'(1);
          ev    = (cnt_q == CNT_W'(1));
        end
      end else begin
        cnt_n = cnt_q - CNT_W'(1);
        ev    = (cnt_q == CNT_W'(1));
      end
    end
    if (wr_ld) begin
      cnt_n = wdata;
      ld_n  = wdata;
      ev    = (wdata == '0);
    end
    if (wr_bg) begin
      ld_n = wdata;
      bg_n = wdata;
    end
    if (wr_ctl) ctl_n = wdata[CTL_W-1:0];
    ris_n = ev | (ris_q & ~(wr_clr & wdata[0]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ld_q  <= '0;
      bg_q  <= '0;
      ctl_q <= '0;
      ris_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      ld_q  <= ld_n;
      bg_q  <= bg_n;
      ctl_q <= ctl_n;
      ris_q <= ris_n;
      irq_q <= ris_n & ctl_n[CB_IE];
    end
  end
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
  import dtmr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic            hit;
  logic [CH_W-1:0] ch_idx;
  reg_idx_e        reg_idx;

  logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt, ch_ld, ch_bg;
  logic [NUM_CH-1:0][CTL_W-1:0] ch_ctl;
  logic [NUM_CH-1:0]            ch_ris;

  dtmr_dec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .addr    (bus_addr),
    .hit     (hit),
    .ch_idx  (ch_idx),
    .reg_idx (reg_idx)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sel;
    assign sel = bus_wr && hit && (ch_idx == CH_W'(c));
    dtmr_chan #(.CNT_W(CNT_W)) u_chan (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick),
      .wr_ld  (sel && reg_idx == RI_LOAD),
      .wr_bg  (sel && reg_idx == RI_BG),
      .wr_ctl (sel && reg_idx == RI_CTRL),
      .wr_clr (sel && reg_idx == RI_CLEAR),
      .wdata  (bus_wdata),
      .cnt_q  (ch_cnt[c]),
      .ld_q   (ch_ld[c]),
      .bg_q   (ch_bg[c]),
      .ctl_q  (ch_ctl[c]),
      .ris_q  (ch_ris[c]),
      .irq_q  (irq[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || !bus_rd || !hit) begin
      bus_rdata <= '0;
    end else begin
      unique case (reg_idx)
        RI_LOAD:  bus_rdata <= ch_ld[ch_idx];
        RI_VALUE: bus_rdata <= ch_cnt[ch_idx];
        RI_CTRL:  bus_rdata <= CNT_W'(ch_ctl[ch_idx]);
        RI_RAW:   bus_rdata <= CNT_W'(ch_ris[ch_idx]);
        RI_MASK:  bus_rdata <= CNT_W'(ch_ris[ch_idx] & ch_ctl[ch_idx][CB_IE]);
        RI_BG:    bus_rdata <= ch_bg[ch_idx];
        default:  bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dtmr_chk.sv
module dtmr_chk
  import dtmr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         tick,
  input logic                         bus_wr,
  input logic                         bus_rd,
  input logic [CNT_W-1:0]             bus_rdata,
  input logic [NUM_CH-1:0]            irq,
  input logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt,
  input logic [NUM_CH-1:0][CTL_W-1:0] ch_ctl,
  input logic [NUM_CH-1:0]            ch_ris
);
  p_rdata_idle_r12: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> bus_rdata == '0);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    p_irq_masked_r10: assert property (@(posedge clk) disable iff (rst)
      irq[i] == (ch_ris[i] && ch_ctl[i][CB_IE]));

    p_pause_holds_r3: assert property (@(posedge clk) disable iff (rst)
      (!bus_wr && (!ch_ctl[i][CB_RUN] || !tick)) |=> $stable(ch_cnt[i]));

    p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
      (!bus_wr && tick && ch_ctl[i][CB_RUN] && ch_cnt[i] > CNT_W'(1))
      |=> ch_cnt[i] == $past(ch_cnt[i]) - CNT_W'(1));

    p_oneshot_halt_r5: assert property (@(posedge clk) disable iff (rst)
      (!bus_wr && ch_ctl[i][CB_ONESHOT] && !ch_ctl[i][CB_PERIODIC] && ch_cnt[i] == '0)
      |=> ch_cnt[i] == '0);

    p_event_flags_r6: assert property (@(posedge clk) disable iff (rst)
      (!bus_wr && tick && ch_ctl[i][CB_RUN] && ch_cnt[i] == CNT_W'(1)) |=> ch_ris[i]);
  end
endmodule

bind dual_tick_timer dtmr_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .ch_cnt    (ch_cnt),
  .ch_ctl    (ch_ctl),
  .ch_ris    (ch_ris)
);

// File: tb/sim_dual_tick_timer.sv
module sim_dual_tick_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  string cur_tag = "R12";
  string exp_tag = "R12";

  always #4 clk = ~clk;

  dual_tick_timer u0 (
    .clk(clk), .rst(rst), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // behavioural reference model
  logic [31:0] m_cnt[2], m_ld[2], m_bg[2];
  logic [7:0]  m_ctl[2];
  logic        m_ris[2];
  logic [31:0] exp_rd;
  logic [1:0]  exp_irq;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      for (int c = 0; c < 2; c++) begin
        m_cnt[c] = 0; m_ld[c] = 0; m_bg[c] = 0; m_ctl[c] = 0; m_ris[c] = 0;
      end
      exp_rd = 0; exp_irq = 0; exp_tag = "R1";
    end else begin
      int a, c0, idx;
      a = int'(bus_addr);
      c0 = (a >> 5) & 1;
      idx = (a >> 2) & 7;
      exp_rd = 0;
      exp_tag = bus_rd ? cur_tag : "R12";
      if (bus_rd && a < 64 && (a % 4) == 0) begin
        case (idx)
          0: exp_rd = m_ld[c0];
          1: exp_rd = m_cnt[c0];
          2: exp_rd = {24'd0, m_ctl[c0]};
          4: exp_rd = {31'd0, m_ris[c0]};
          5: exp_rd = {31'd0, m_ris[c0] & m_ctl[c0][5]};
          6: exp_rd = m_bg[c0];
          default: exp_rd = 0;
        endcase
      end
      for (int c = 0; c < 2; c++) begin
        bit hitc, ev, clr;
        logic [31:0] ncnt;
        hitc = bus_wr && a < 64 && (a % 4) == 0 && c0 == c;
        ev = 0; clr = 0; ncnt = m_cnt[c];
        if (m_ctl[c][7] && tick) begin
          if (m_ctl[c][6]) begin
            if (m_cnt[c] <= 1) begin ncnt = m_ld[c]; ev = 1; end
            else ncnt = m_cnt[c] - 1;
          end else if (m_ctl[c][0]) begin
            if (m_cnt[c] != 0) begin ncnt = m_cnt[c] - 1; ev = (m_cnt[c] == 1); end
          end else begin
            ncnt = m_cnt[c] - 1; ev = (m_cnt[c] == 1);
          end
        end
        if (hitc) begin
          case (idx)
            0: begin ncnt = bus_wdata; m_ld[c] = bus_wdata; ev = (bus_wdata == 0); end
            2: m_ctl[c] = bus_wdata[7:0];
            3: clr = bus_wdata[0];
            6: begin m_ld[c] = bus_wdata; m_bg[c] = bus_wdata; end
            default: ;
          endcase
        end
        m_cnt[c] = ncnt;
        m_ris[c] = ev ? 1'b1 : (clr ? 1'b0 : m_ris[c]);
        exp_irq[c] = m_ris[c] & m_ctl[c][5];
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R10 irq", {30'd0, irq}, {30'd0, exp_irq});
      chk(exp_tag, bus_rdata, exp_rd);
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d, logic t = 1'b0);
    @(negedge clk);
    bus_wr = 1; bus_rd = 0; bus_addr = a; bus_wdata = d; tick = t;
  endtask

  task automatic rd(logic [7:0] a, string tag, logic t = 1'b0);
    @(negedge clk);
    bus_wr = 0; bus_rd = 1; bus_addr = a; tick = t; cur_tag = tag;
  endtask

  task automatic idle(int n, logic t);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_wr = 0; bus_rd = 0; tick = t;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected finish before 150000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state of both sets
    for (int s = 0; s < 2; s++)
      for (int r = 0; r < 8; r++) rd(8'((s << 5) | (r << 2)), "R1");
    // R2 load and read-only value
    wr(8'h00, 32'd5);
    rd(8'h04, "R2");
    wr(8'h04, 32'h99);
    rd(8'h04, "R2");
    rd(8'h00, "R2");
    // R3 counting and pause
    wr(8'h08, 32'hA3);
    idle(3, 1);
    rd(8'h04, "R3");
    idle(3, 0);
    rd(8'h04, "R3");
    wr(8'h08, 32'h23);
    idle(3, 1);
    rd(8'h04, "R3");
    // R5 one-shot terminal
    wr(8'h08, 32'hA3);
    idle(6, 1);
    rd(8'h04, "R5", 1);
    rd(8'h10, "R5");
    rd(8'h14, "R10");
    // R9 clear semantics
    wr(8'h0C, 32'h0);
    rd(8'h10, "R9");
    wr(8'h0C, 32'h1);
    rd(8'h10, "R9");
    // R4 zero load on the second set, R11 independence
    wr(8'h28, 32'h20);
    wr(8'h20, 32'h0);
    rd(8'h30, "R4");
    rd(8'h34, "R11");
    rd(8'h10, "R11");
    // R6/R7 periodic with background reload
    wr(8'h08, 32'h0);
    wr(8'h00, 32'd3);
    wr(8'h08, 32'hE2);
    idle(7, 1);
    rd(8'h04, "R6");
    rd(8'h10, "R6");
    wr(8'h18, 32'd10, 1);
    rd(8'h04, "R7");
    rd(8'h00, "R7");
    rd(8'h18, "R7");
    idle(4, 1);
    rd(8'h04, "R7");
    idle(9, 1);
    rd(8'h04, "R7");
    // R8 free-running wrap on the second set
    wr(8'h28, 32'h0);
    wr(8'h2C, 32'h1);
    wr(8'h20, 32'd1);
    wr(8'h28, 32'hA2);
    idle(1, 1);
    rd(8'h30, "R8");
    idle(1, 1);
    rd(8'h24, "R8");
    // R10 enable off hides interrupt
    wr(8'h28, 32'h02);
    rd(8'h34, "R10");
    rd(8'h30, "R10");
    // R12 unmapped reads and writes
    rd(8'h40, "R12");
    rd(8'h0C, "R12");
    rd(8'h1C, "R12");
    rd(8'h01, "R12");
    wr(8'h41, 32'hFFFF);
    wr(8'h02, 32'h7);
    rd(8'h00, "R12");
    // R13 load wins over tick
    wr(8'h00, 32'd50, 1);
    rd(8'h04, "R13", 1);
    // R9 event beats clear: periodic load 1 flags every tick
    wr(8'h0C, 32'h1);
    wr(8'h00, 32'd1);
    wr(8'h18, 32'd1);
    idle(2, 1);
    wr(8'h0C, 32'h1, 1);
    rd(8'h10, "R9");
    idle(3, 0);
    finish_run();
  end
endmodule